// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Read Snapshot

This block keeps a 12-hour wall-clock time as packed BCD digits: tenths of a second, seconds, minutes and hours, plus an AM/PM flag. A free-running phase counter opens a count window on one system clock in four. A tenth-of-a-second tick arriving at any time is held pending until the next window, so each tick advances the time by exactly one tenth. Each BCD digit has its own count and clear strobe, and the carry passes from the tenths digit up to the hours. The hour digit pair wraps 12 to 01 by loading its lowest bit with the inverse of the next hour-tens value, where the other digits clear.

Software reads the time one byte at a time through an 8-bit port while counting continues. A snapshot register normally follows the live count. Reading the hours byte freezes it, so the minutes, seconds and tenths bytes read afterwards belong to the same instant. Reading the tenths byte releases it again.

Top module: `tod_counter`

## Requirements
- R1: After reset the live time is 01:00:00.0 AM (`time_o` = 26'h0100000), the snapshot follows the live count, and reading the hours byte returns 8'h01.
- R2: The time changes only in count windows, which open one clock in every four. With `tick_i` held high, the tenths digit advances exactly 10 times in any 40 consecutive clocks.
- R3: A one-cycle `tick_i` pulse is held pending until the next count window and advances the time by exactly one tenth. Pulses at least five clocks apart are each counted once.
- R4: A digit advances only when it receives a carry. On a carry at its limit (9 for units and tenths, 5 for tens of seconds and minutes) it clears to 0 and passes the carry to the next digit.
- R5: Seconds wrap 59 to 00 and carry into minutes. Minutes wrap 59 to 00 and carry into hours.
- R6: The hours go 09 to 10, and the hour value always stays within 01..12.
- R7: The hours go from 11 to 12 on a carry, and the AM/PM flag toggles at that moment and at no other.
- R8: The hours go from 12 to 01 on a carry, with the AM/PM flag unchanged, so 12:59:59.9 is followed by 01:00:00.0.
- R9: `rd_data_o` shows the byte selected by `rd_sel_i`: 0 gives tenths {4'h0, tenths}, 1 gives seconds {tens, units}, 2 gives minutes {tens, units}, 3 gives hours {pm, 2'b00, hour tens bit, hour units}. `time_o` packs {pm, hour tens bit, hour units, minute tens, minute units, second tens, second units, tenths}, from MSB to LSB, four bits per digit.
- R10: A read with select 3 freezes the snapshot at the value of that cycle. Later reads of the seconds and minutes bytes return the frozen values while `time_o` keeps counting.
- R11: A read with select 0 returns the frozen tenths and releases the freeze. Reads after that follow the live count again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One pulse per tenth of a second |
| rd_en_i | input | 1 | Byte read strobe |
| rd_sel_i | input | 2 | Byte select: 0 tenths, 1 seconds, 2 minutes, 3 hours |
| time_o | output | 26 | Live packed BCD time with AM/PM flag |
| rd_data_o | output | 8 | Selected byte of the snapshot view |

## Verification
Widely spaced single ticks check that every pulse is counted once. A tick held high for 40 clocks separates the divide-by-four window from one step per clock and from lost pending ticks. Random bursts with random gaps, against a bench time model, test carries across several digits. A 600-tick run drives the seconds wrap into minutes. A separate hour-digit instance steps through a full 24-hour cycle, which separates the 09-to-10, 11-to-12 and 12-to-01 rules and the AM/PM toggle. Read sequences that advance the time between the hours read and the tenths read show whether the snapshot freezes and releases as specified.

// File: rtl/tod_pkg.sv
package tod_pkg;

    localparam int unsigned DIGIT_W  = 4;
    localparam int unsigned NUM_DIG  = 5;   // tenths, sec units, sec tens, min units, min tens
    localparam int unsigned DIV      = 4;   // count window period in clocks

    typedef enum logic [1:0] {
        SEL_TENTHS = 2'd0,
        SEL_SEC    = 2'd1,
        SEL_MIN    = 2'd2,
        SEL_HR     = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic               pm;
        logic               hh;
        logic [DIGIT_W-1:0] hl;
        logic [DIGIT_W-1:0] mt;
        logic [DIGIT_W-1:0] mu;
        logic [DIGIT_W-1:0] st;
        logic [DIGIT_W-1:0] su;
        logic [DIGIT_W-1:0] tn;
    } tod_time_t;

    localparam tod_time_t RESET_TIME = '{pm: 1'b0, hh: 1'b0, hl: 4'd1,
                                         mt: 4'd0, mu: 4'd0, st: 4'd0,
                                         su: 4'd0, tn: 4'd0};

    // Limit of each lower digit, index 0 is the tenths digit
    function automatic int unsigned digit_limit(input int unsigned idx);
        return (idx == 2 || idx == 4) ? 5 : 9;
    endfunction

    function automatic logic [7:0] byte_of(input tod_time_t t, input rd_sel_e s);
        case (s)
            SEL_TENTHS: return {4'h0, t.tn};
            SEL_SEC:    return {t.st, t.su};
            SEL_MIN:    return {t.mt, t.mu};
            default:    return {t.pm, 2'b00, t.hh, t.hl};
        endcase
    endfunction

endpackage

// File: rtl/tod_digit.sv
module tod_digit #(
    parameter int unsigned LIMIT = 9,
    parameter int unsigned DW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_i,
    output logic [DW-1:0] val_o,
    output logic          tc_o
);
    localparam logic [DW-1:0] LIM = DW'(LIMIT);

    logic clr;

    assign tc_o = cnt_i && (val_o == LIM);
    assign clr  = tc_o;

    always_ff @(posedge clk) begin
        if (rst)        val_o <= '0;
        else if (clr)   val_o <= '0;
        else if (cnt_i) val_o <= val_o + 1'b1;
    end

    a_r4_digit_range: assert property (@(posedge clk) disable iff (rst)
        val_o <= LIM);
    a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_i && val_o == LIM) |=> (val_o == '0));
    a_r4_idle: assert property (@(posedge clk) disable iff (rst)
        !cnt_i |=> $stable(val_o));

endmodule

// File: rtl/tod_hour.sv
module tod_hour #(
    parameter int unsigned DW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_i,
    output logic          hh_o,
    output logic [DW-1:0] hl_o,
    output logic          pm_o
);
    logic is_nine, is_eleven, is_twelve;
    logic hh_nxt, hl_clr;

    assign is_nine   = (hl_o == DW'(9));
    assign is_eleven = hh_o && (hl_o == DW'(1));
    assign is_twelve = hh_o && (hl_o == DW'(2));

    always_comb begin
        hh_nxt = hh_o;
        if (cnt_i && is_nine)   hh_nxt = 1'b1;
        if (cnt_i && is_twelve) hh_nxt = 1'b0;
    end

    // The clear strobe leaves bit 0 to the inverse of the new tens bit
    assign hl_clr = cnt_i && (is_nine || is_twelve);

    always_ff @(posedge clk) begin
        if (rst) begin
            hh_o <= 1'b0;
            hl_o <= DW'(1);
            pm_o <= 1'b0;
        end else begin
            hh_o <= hh_nxt;
            if (hl_clr)     hl_o <= {{(DW-1){1'b0}}, ~hh_nxt};
            else if (cnt_i) hl_o <= hl_o + 1'b1;
            if (cnt_i && is_eleven) pm_o <= ~pm_o;
        end
    end

    a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
        (cnt_i && hh_o && hl_o == DW'(2)) |=> (!hh_o && hl_o == DW'(1)));
    a_r7_pm_toggle: assert property (@(posedge clk) disable iff (rst)
        !$stable(pm_o) |-> $past(cnt_i && hh_o && hl_o == DW'(1)));
    a_r6_range_hi: assert property (@(posedge clk) disable iff (rst)
        hh_o |-> (hl_o <= DW'(2)));
    a_r6_range_lo: assert property (@(posedge clk) disable iff (rst)
        !hh_o |-> (hl_o != '0 && hl_o <= DW'(9)));

endmodule

// File: rtl/tod_snap.sv
module tod_snap
    import tod_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tod_time_t live_i,
    input  logic      rd_en_i,
    input  rd_sel_e   rd_sel_i,
    output logic [7:0] rd_data_o
);
    tod_time_t snap_q, view;
    logic      hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= 1'b0;
            snap_q <= RESET_TIME;
        end else begin
            if (!hold_q) snap_q <= live_i;
            if (rd_en_i && rd_sel_i == SEL_HR)     hold_q <= 1'b1;
            if (rd_en_i && rd_sel_i == SEL_TENTHS) hold_q <= 1'b0;
        end
    end

    assign view      = hold_q ? snap_q : live_i;
    assign rd_data_o = byte_of(view, rd_sel_i);

    a_r10_freeze_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_q) |-> $past(rd_en_i && rd_sel_i == SEL_HR));
    a_r11_release_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_q) |-> $past(rd_en_i && rd_sel_i == SEL_TENTHS));

endmodule

// File: rtl/tod_counter.sv
module tod_counter
    import tod_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_i,
    input  logic        rd_en_i,
    input  logic [1:0]  rd_sel_i,
    output logic [25:0] time_o,
    output logic [7:0]  rd_data_o
);
    localparam int unsigned PW = $clog2(DIV);

    logic [PW-1:0]      phase_q;
    logic               win, pend_q, adv;
    logic [DIGIT_W-1:0] dig   [NUM_DIG];
    logic               carry [NUM_DIG+1];
    tod_time_t          live;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            pend_q  <= 1'b0;
        end else begin
            phase_q <= phase_q + 1'b1;
            pend_q  <= win ? 1'b0 : (pend_q | tick_i);
        end
    end

    assign win      = (phase_q == PW'(DIV-1));
    assign adv      = win && (tick_i || pend_q);
    assign carry[0] = adv;

    for (genvar g = 0; g < NUM_DIG; g++) begin : g_dig
        tod_digit #(.LIMIT(digit_limit(g)), .DW(DIGIT_W)) u_dig (
            .clk   (clk),
            .rst   (rst),
            .cnt_i (carry[g]),
            .val_o (dig[g]),
            .tc_o  (carry[g+1])
        );
    end

    tod_hour #(.DW(DIGIT_W)) u_hour (
        .clk   (clk),
        .rst   (rst),
        .cnt_i (carry[NUM_DIG]),
        .hh_o  (live.hh),
        .hl_o  (live.hl),
        .pm_o  (live.pm)
    );

    assign live.tn = dig[0];
    assign live.su = dig[1];
    assign live.st = dig[2];
    assign live.mu = dig[3];
    assign live.mt = dig[4];
    assign time_o  = live;

    tod_snap u_snap (
        .clk       (clk),
        .rst       (rst),
        .live_i    (live),
        .rd_en_i   (rd_en_i),
        .rd_sel_i  (rd_sel_e'(rd_sel_i)),
        .rd_data_o (rd_data_o)
    );

    a_r2_window_only: assert property (@(posedge clk) disable iff (rst)
        !$stable(time_o) |-> $past(win));
    a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
        !$stable(time_o) |-> (time_o[3:0] == (($past(time_o[3:0]) == 4'd9) ? 4'd0 : $past(time_o[3:0]) + 4'd1)));

endmodule

// File: tb/tb_tod_counter.sv
module tb_tod_counter;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  rd_sel_i = 2'd0;
    logic [25:0] time_o;
    logic [7:0]  rd_data_o;

    logic        h_cnt = 1'b0;
    logic        h_hh, h_pm;
    logic [3:0]  h_hl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tod_counter dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .rd_en_i(rd_en_i),
        .rd_sel_i(rd_sel_i), .time_o(time_o), .rd_data_o(rd_data_o)
    );

    tod_hour #(.DW(4)) hu (
        .clk(clk), .rst(rst), .cnt_i(h_cnt), .hh_o(h_hh), .hl_o(h_hl), .pm_o(h_pm)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Hour step as given by R6, R7, R8: value {pm, hh, hl}
    function automatic logic [5:0] hour_step(input logic [5:0] h);
        logic pm, hh; logic [3:0] hl;
        {pm, hh, hl} = h;
        if (hh && hl == 4'd2)      begin hh = 1'b0; hl = 4'd1; end
        else if (hh && hl == 4'd1) begin hl = 4'd2; pm = ~pm; end
        else if (hl == 4'd9)       begin hh = 1'b1; hl = 4'd0; end
        else                        hl = hl + 4'd1;
        return {pm, hh, hl};
    endfunction

    // One tenth step on the packed layout of R9
    function automatic logic [25:0] step_t(input logic [25:0] t);
        logic [3:0] d [5];
        logic [5:0] h;
        logic       c;
        for (int i = 0; i < 5; i++) d[i] = t[i*4 +: 4];
        h = t[25:20];
        c = 1'b1;
        for (int i = 0; i < 5; i++) begin
            if (c) begin
                if (d[i] == ((i == 2 || i == 4) ? 4'd5 : 4'd9)) d[i] = 4'd0;
                else begin d[i] = d[i] + 4'd1; c = 1'b0; end
            end
        end
        if (c) h = hour_step(h);
        return {h, d[4], d[3], d[2], d[1], d[0]};
    endfunction

    function automatic logic [25:0] add_t(input logic [25:0] t, input int n);
        logic [25:0] r = t;
        for (int i = 0; i < n; i++) r = step_t(r);
        return r;
    endfunction

    task automatic one_tick(input int extra);
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        repeat (4 + extra) @(negedge clk);
    endtask

    task automatic do_read(input logic [1:0] sel, output logic [7:0] data);
        @(negedge clk);
        rd_en_i = 1'b1; rd_sel_i = sel;
        #1 data = rd_data_o;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [25:0] base, expv;
        logic [7:0]  rb;
        logic [5:0]  hm;
        int          changes;
        void'($urandom(32'h5EED_1234));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 reset time", 32'(time_o), 32'h0100000);
        @(negedge clk) rd_sel_i = 2'd3;
        #1 check("R1 hours byte", 32'(rd_data_o), 32'h01);
        repeat (8) @(negedge clk);
        check("R1 idle without ticks", 32'(time_o), 32'h0100000);

        // R3 single pulse, R4 tenths carry into seconds
        one_tick(0);
        check("R3 single tick", 32'(time_o), 32'h0100001);
        for (int i = 0; i < 9; i++) one_tick(i % 3);
        check("R4 tenths carry", 32'(time_o), 32'h0100010);

        // R2 divide-by-four rate with tick held high
        base = time_o;
        changes = 0;
        @(negedge clk) tick_i = 1'b1;
        for (int i = 0; i < 40; i++) begin
            logic [25:0] prev;
            prev = time_o;
            @(negedge clk);
            if (time_o != prev) changes++;
        end
        tick_i = 1'b0;
        check("R2 advances in 40 clocks", 32'(changes), 32'd10);
        repeat (8) @(negedge clk);

        // R3 R4 random bursts of spaced ticks
        for (int k = 0; k < 30; k++) begin
            int n;
            n = int'($urandom_range(1, 25));
            base = time_o;
            for (int i = 0; i < n; i++) one_tick(int'($urandom_range(0, 3)));
            check("R3 R4 random burst", 32'(time_o), 32'(add_t(base, n)));
        end

        // R5 seconds wrap into minutes
        base = time_o;
        for (int i = 0; i < 600; i++) one_tick(0);
        expv = add_t(base, 600);
        check("R5 one minute later", 32'(time_o), 32'(expv));
        check("R5 minute units moved", 32'(time_o[15:12]), 32'(base[15:12] + 4'd1));

        // R9 R10 freeze on hours read
        base = time_o;
        do_read(2'd3, rb);
        check("R9 hours byte layout", 32'(rb), {24'h0, base[25], 2'b00, base[24:20]});
        for (int i = 0; i < 15; i++) one_tick(0);
        check("R10 live keeps counting", 32'(time_o), 32'(add_t(base, 15)));
        do_read(2'd1, rb);
        check("R10 frozen seconds", 32'(rb), 32'(base[11:4]));
        do_read(2'd2, rb);
        check("R10 frozen minutes", 32'(rb), 32'(base[19:12]));
        do_read(2'd0, rb);
        check("R11 frozen tenths on release", 32'(rb), {28'h0, base[3:0]});

        // R11 live after release
        for (int i = 0; i < 12; i++) one_tick(0);
        base = time_o;
        do_read(2'd1, rb);
        check("R11 live seconds after release", 32'(rb), 32'(base[11:4]));
        do_read(2'd0, rb);
        check("R9 tenths byte layout", 32'(rb), {28'h0, base[3:0]});

        // R6 R7 R8 full cycle of the hour digit pair
        hm = {h_pm, h_hh, h_hl};
        check("R6 hour unit reset", 32'(hm), 32'h01);
        for (int i = 0; i < 24; i++) begin
            logic [5:0] exph;
            exph = hour_step(hm);
            @(negedge clk) h_cnt = 1'b1;
            @(negedge clk) h_cnt = 1'b0;
            hm = {h_pm, h_hh, h_hl};
            if (exph[4:0] == 5'h10)
                check("R6 nine to ten", 32'(hm), 32'(exph));
            else if (exph[4:0] == 5'h12)
                check("R7 eleven to twelve, pm toggle", 32'(hm), 32'(exph));
            else if (exph[4:0] == 5'h01)
                check("R8 twelve to one", 32'(hm), 32'(exph));
            else
                check("R6 hour step", 32'(hm), 32'(exph));
        end
        check("R7 back to AM after full day", 32'(hm), 32'h01);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule